// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial memory link with 64 words of 16 bits. A command arrives as a single-cycle start request with a command code, a 6-bit word address and a 16-bit data word. The controller builds the serial frame and drives chip select, the serial clock and the serial data line from the system clock. The serial clock rate is set by a divider parameter. For a read, it shifts the returned word in from the memory's data output.

After any command that programs the array, the controller drops chip select for a minimum number of cycles. It then raises chip select again, without clocking, and watches the data output until the memory reports ready. A bounded poll window guards against a memory that never reports ready. The command closes with a single-cycle done pulse. The read word and a timeout flag are valid from that pulse onward.

Top module: `eep_host_ctrl`

## Requirements
- R1: Every frame starts with chip select rising and a 1 start bit, followed by a 2-bit opcode and a 6-bit address, both MSB first. Command codes on `cmd_op_i` are 0 read (opcode 10), 1 write (01), 2 erase (11) and 3 unlock (00, address 11xxxx). The rest are 4 lock (00, address 00xxxx), 5 clear-all (00, address 10xxxx) and 6 write-all (00, address 01xxxx); code 7 is sent as lock. The low address bits of the four 00 commands are sent as 0. A frame without data has exactly 9 serial clocks.
- R2: Write and write-all frames append the 16 data bits MSB first, so each such frame has exactly 25 serial clocks.
- R3: A read frame has 26 serial clocks. The value sampled on the 10th rising edge is a dummy and is dropped. The next 16 samples form `rd_data_o`, MSB first.
- R4: The serial clock stays low for `HALF_DIV` cycles and high for `HALF_DIV` cycles. DI changes only while the clock is low. The clock is low whenever chip select is low.
- R5: Chip select stays low for at least `CS_LOW_CYC` cycles between any fall and the next rise.
- R6: After write, erase, clear-all and write-all, chip select rises again after the gap, with no serial clocks. The command completes on the first DO high seen after the first poll cycle, with the timeout flag clear.
- R7: If DO stays low for `POLL_LIMIT` poll cycles, chip select drops and done is raised with `timeout_o` high. `timeout_o` clears on the next accepted start.
- R8: A start request while busy is ignored; the running command is not altered and no extra command runs.
- R9: `busy_o` is high from the cycle after an accepted start until done. `done_o` is a one-cycle pulse.
- R10: After reset, chip select, serial clock, busy, done, timeout and the read word are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command request, one cycle |
| cmd_op_i | input | 3 | Command code (see R1) |
| cmd_addr_i | input | 6 | Word address |
| cmd_wdata_i | input | 16 | Data for write and write-all |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Completion pulse |
| timeout_o | output | 1 | Poll window ran out on the last command |
| rd_data_o | output | 16 | Word returned by the last read |
| ee_cs_o | output | 1 | Chip select to the memory |
| ee_sk_o | output | 1 | Serial clock to the memory |
| ee_di_o | output | 1 | Serial data to the memory |
| ee_do_i | input | 1 | Serial data and status from the memory |

## Verification
The hardest states to reach from the ports are a memory that never leaves busy and a second start that lands in mid-frame. A behavioural memory model in the bench reacts to the serial pins. It has a stuck flag that holds its status low, which forces the poll window to run out. A directed test pulses start a few cycles into a read with a conflicting write command. It then checks that only one done appears and that the target word is untouched.

// File: rtl/eep_host_pkg.sv
`timescale 1ns/1ps
package eep_host_pkg;

    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 16;
    localparam int OPC_W   = 2;
    localparam int HDR_W   = 1 + OPC_W + ADDR_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int RX_BITS = DATA_W + 1;
    localparam int CNT_W   = $clog2(HDR_W + RX_BITS + 1);

    typedef enum logic [2:0] {
        CMD_READ      = 3'd0,
        CMD_WRITE     = 3'd1,
        CMD_ERASE     = 3'd2,
        CMD_UNLOCK    = 3'd3,
        CMD_LOCK      = 3'd4,
        CMD_CLEAR_ALL = 3'd5,
        CMD_WRITE_ALL = 3'd6
    } ee_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GAP,
        ST_POLL
    } ee_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] tx;
        logic [CNT_W-1:0]   tx_len;
        logic [CNT_W-1:0]   total;
        logic               prog;
    } frame_t;

    function automatic logic [ADDR_W-1:0] sel_field(input logic [1:0] sel);
        return {sel, {(ADDR_W-2){1'b0}}};
    endfunction

    function automatic frame_t build_frame(input ee_cmd_e          cmd,
                                           input logic [ADDR_W-1:0] addr,
                                           input logic [DATA_W-1:0] wdata);
        frame_t            f;
        logic [OPC_W-1:0]  opc;
        logic [ADDR_W-1:0] af;
        logic              with_data;
        opc       = 2'b00;
        af        = addr;
        with_data = 1'b0;
        f.prog    = 1'b1;
        case (cmd)
            CMD_READ:      begin opc = 2'b10; f.prog = 1'b0; end
            CMD_WRITE:     begin opc = 2'b01; with_data = 1'b1; end
            CMD_ERASE:     begin opc = 2'b11; end
            CMD_UNLOCK:    begin af = sel_field(2'b11); f.prog = 1'b0; end
            CMD_CLEAR_ALL: begin af = sel_field(2'b10); end
            CMD_WRITE_ALL: begin af = sel_field(2'b01); with_data = 1'b1; end
            default:       begin af = sel_field(2'b00); f.prog = 1'b0; end
        endcase
        f.tx     = {1'b1, opc, af, (with_data ? wdata : {DATA_W{1'b0}})};
        f.tx_len = with_data ? CNT_W'(FRAME_W) : CNT_W'(HDR_W);
        f.total  = (cmd == CMD_READ) ? CNT_W'(HDR_W + RX_BITS) : f.tx_len;
        return f;
    endfunction

endpackage

// File: rtl/eep_sk_timer.sv
`timescale 1ns/1ps
module eep_sk_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)                 cnt <= '0;
        else if (cnt == W'(HALF_DIV-1))  cnt <= '0;
        else                             cnt <= cnt + W'(1);
    end

    assign tick = run && (cnt == W'(HALF_DIV-1));

    // R4: a running timer never ticks on two adjacent cycles unless divide is 1
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (HALF_DIV > 1) && tick && run |=> !tick);
endmodule

// File: rtl/eep_wait_ctr.sv
`timescale 1ns/1ps
module eep_wait_ctr #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= W'(LIMIT - 1);
        else if (cnt != '0)    cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);

    // R5/R7: windows shrink by exactly one per cycle
    p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
        !load && (cnt != '0) |=> cnt == $past(cnt) - W'(1));
endmodule

// File: rtl/eep_host_ctrl.sv
`timescale 1ns/1ps
module eep_host_ctrl
    import eep_host_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int CS_LOW_CYC = 63,
    parameter int POLL_LIMIT = 1250000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [2:0]  cmd_op_i,
    input  logic [5:0]  cmd_addr_i,
    input  logic [15:0] cmd_wdata_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        timeout_o,
    output logic [15:0] rd_data_o,
    output logic        ee_cs_o,
    output logic        ee_sk_o,
    output logic        ee_di_o,
    input  logic        ee_do_i
);
    localparam int LOW_W = $clog2(CS_LOW_CYC + 1);

    ee_state_e          state;
    frame_t             frm;
    logic [FRAME_W-1:0] tx_sh;
    logic [DATA_W-1:0]  rx_sh;
    logic [CNT_W-1:0]   bit_cnt;
    logic               go_done;
    logic               tmo_pend;
    logic               poll_first;
    logic               sk_tick;
    logic               gap_exp;
    logic               poll_exp;
    logic               frame_end;
    logic               poll_ready;
    logic               poll_quit;
    logic               gap_load;
    logic               poll_load;

    eep_sk_timer #(.HALF_DIV(HALF_DIV)) u_sk (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_SHIFT),
        .tick (sk_tick)
    );

    eep_wait_ctr #(.LIMIT(CS_LOW_CYC)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (gap_load),
        .expired (gap_exp)
    );

    eep_wait_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst     (rst),
        .load    (poll_load),
        .expired (poll_exp)
    );

    always_comb begin
        frame_end  = (state == ST_SHIFT) && sk_tick && ee_sk_o && (bit_cnt == frm.total);
        poll_ready = (state == ST_POLL) && !poll_first && ee_do_i;
        poll_quit  = (state == ST_POLL) && (poll_ready || poll_exp);
        gap_load   = frame_end || poll_quit;
        poll_load  = (state == ST_GAP) && gap_exp && !go_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            frm        <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            bit_cnt    <= '0;
            go_done    <= 1'b0;
            tmo_pend   <= 1'b0;
            poll_first <= 1'b0;
            done_o     <= 1'b0;
            timeout_o  <= 1'b0;
            ee_cs_o    <= 1'b0;
            ee_sk_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        frm       <= build_frame(ee_cmd_e'(cmd_op_i), cmd_addr_i, cmd_wdata_i);
                        tx_sh     <= build_frame(ee_cmd_e'(cmd_op_i), cmd_addr_i, cmd_wdata_i).tx;
                        bit_cnt   <= '0;
                        tmo_pend  <= 1'b0;
                        timeout_o <= 1'b0;
                        ee_cs_o   <= 1'b1;
                        ee_sk_o   <= 1'b0;
                        state     <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (sk_tick) begin
                        if (!ee_sk_o) begin
                            ee_sk_o <= 1'b1;
                            bit_cnt <= bit_cnt + CNT_W'(1);
                            if (bit_cnt >= frm.tx_len)
                                rx_sh <= {rx_sh[DATA_W-2:0], ee_do_i};
                        end else begin
                            ee_sk_o <= 1'b0;
                            if (frame_end) begin
                                ee_cs_o <= 1'b0;
                                go_done <= !frm.prog;
                                state   <= ST_GAP;
                            end else begin
                                tx_sh <= tx_sh << 1;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_exp) begin
                        if (go_done) begin
                            done_o    <= 1'b1;
                            timeout_o <= tmo_pend;
                            state     <= ST_IDLE;
                        end else begin
                            ee_cs_o    <= 1'b1;
                            poll_first <= 1'b1;
                            state      <= ST_POLL;
                        end
                    end
                end
                ST_POLL: begin
                    poll_first <= 1'b0;
                    if (poll_quit) begin
                        tmo_pend <= !poll_ready;
                        ee_cs_o  <= 1'b0;
                        go_done  <= 1'b1;
                        state    <= ST_GAP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o    = (state != ST_IDLE);
    assign rd_data_o = rx_sh;
    assign ee_di_o   = (state == ST_SHIFT) && tx_sh[FRAME_W-1];

    // Checker state: length of the current chip-select low run, saturating
    logic [LOW_W-1:0] low_run;
    always_ff @(posedge clk) begin
        if (rst)                               low_run <= LOW_W'(CS_LOW_CYC);
        else if (ee_cs_o)                      low_run <= '0;
        else if (low_run != LOW_W'(CS_LOW_CYC)) low_run <= low_run + LOW_W'(1);
    end

    p_sk_low_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !ee_cs_o |-> !ee_sk_o);

    p_di_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ee_sk_o && $past(ee_sk_o) |-> $stable(ee_di_o));

    p_cs_gap_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_cs_o) |-> low_run >= LOW_W'(CS_LOW_CYC));

    p_poll_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        state == ST_POLL |-> ee_cs_o && !ee_sk_o);

    p_tmo_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> done_o);

    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy_o && $past(busy_o) |-> $stable(frm));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

// File: tb/eep_host_ctrl_tb.sv
`timescale 1ns/1ps
module eep_host_ctrl_tb;
    localparam int HALF  = 2;
    localparam int GAPC  = 4;
    localparam int PLIM  = 300;
    localparam int BUSYC = 40;
    localparam int NVEC  = 16;

    // {op, addr, wdata, expected read, expected serial clocks}
    localparam logic [45:0] VEC [NVEC] = '{
        {3'd3, 6'd0,  16'h0000, 16'h0000, 5'd9},
        {3'd1, 6'd5,  16'hA5C3, 16'h0000, 5'd25},
        {3'd0, 6'd5,  16'h0000, 16'hA5C3, 5'd26},
        {3'd2, 6'd5,  16'h0000, 16'h0000, 5'd9},
        {3'd0, 6'd5,  16'h0000, 16'hFFFF, 5'd26},
        {3'd6, 6'd0,  16'h1234, 16'h0000, 5'd25},
        {3'd0, 6'd63, 16'h0000, 16'h1234, 5'd26},
        {3'd0, 6'd0,  16'h0000, 16'h1234, 5'd26},
        {3'd1, 6'd0,  16'h8001, 16'h0000, 5'd25},
        {3'd0, 6'd0,  16'h0000, 16'h8001, 5'd26},
        {3'd4, 6'd0,  16'h0000, 16'h0000, 5'd9},
        {3'd1, 6'd0,  16'h0000, 16'h0000, 5'd25},
        {3'd0, 6'd0,  16'h0000, 16'h8001, 5'd26},
        {3'd3, 6'd0,  16'h0000, 16'h0000, 5'd9},
        {3'd5, 6'd0,  16'h0000, 16'h0000, 5'd9},
        {3'd0, 6'd17, 16'h0000, 16'hFFFF, 5'd26}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  op_in;
    logic [5:0]  addr_in;
    logic [15:0] wd_in;
    logic        busy, done, tmo;
    logic [15:0] rd;
    logic        cs, sk, di, dout;
    logic        stuck;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    eep_host_ctrl #(.HALF_DIV(HALF), .CS_LOW_CYC(GAPC), .POLL_LIMIT(PLIM)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .cmd_op_i(op_in), .cmd_addr_i(addr_in),
        .cmd_wdata_i(wd_in), .busy_o(busy), .done_o(done), .timeout_o(tmo),
        .rd_data_o(rd), .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(dout)
    );

    // Behavioural memory model, edges detected on the system clock
    logic [15:0] mem [64];
    logic        psk, pcs, en, stat, rd_act, do_reg;
    logic [31:0] sr, nsr;
    int          k, nk, last_clks, busy_cnt, pend;
    logic [1:0]  op_q, sel_q;
    logic [5:0]  padr;
    logic [15:0] pdat, rd_word;

    always @(posedge clk) begin
        if (rst) begin
            psk <= 0; pcs <= 0; en <= 0; stat <= 0; rd_act <= 0; do_reg <= 0;
            sr <= 0; k <= 0; last_clks <= 0; busy_cnt <= 0; pend <= 0;
            op_q <= 0; sel_q <= 0; padr <= 0; pdat <= 0; rd_word <= 0;
            for (int i = 0; i < 64; i++) mem[i] <= 16'h0000;
        end else begin
            psk <= sk;
            pcs <= cs;
            if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
            if (cs && !pcs) begin
                k <= 0;
                rd_act <= 0;
            end
            if (sk && !psk) begin
                nsr = {sr[30:0], di};
                nk  = k + 1;
                sr <= nsr;
                k  <= nk;
                if (nk == 9) begin
                    op_q  <= nsr[7:6];
                    sel_q <= nsr[5:4];
                    padr  <= nsr[5:0];
                    case (nsr[7:6])
                        2'b10: begin rd_act <= 1; rd_word <= mem[nsr[5:0]]; do_reg <= 0; end
                        2'b11: pend <= 1;
                        2'b00: case (nsr[5:4])
                                   2'b11: en <= 1;
                                   2'b00: en <= 0;
                                   2'b10: pend <= 3;
                                   default: ;
                               endcase
                        default: ;
                    endcase
                end
                if (nk == 25) begin
                    pdat <= nsr[15:0];
                    if (op_q == 2'b01) pend <= 2;
                    else if (op_q == 2'b00 && sel_q == 2'b01) pend <= 4;
                end
                if (rd_act && nk >= 10 && nk <= 25) do_reg <= rd_word[25-nk];
            end
            if (!cs && pcs) begin
                if (k != 0) last_clks <= k;
                if (pend != 0) begin
                    stat <= 1;
                    if (en) begin
                        busy_cnt <= BUSYC;
                        case (pend)
                            1: mem[padr] <= 16'hFFFF;
                            2: mem[padr] <= pdat;
                            3: for (int i = 0; i < 64; i++) mem[i] <= 16'hFFFF;
                            default: for (int i = 0; i < 64; i++) mem[i] <= pdat;
                        endcase
                    end
                    pend <= 0;
                end else begin
                    stat <= 0;
                end
            end
        end
    end

    assign dout = stat ? (busy_cnt == 0 && !stuck) : do_reg;

    // Pin monitors for R4 and R5
    int  seg, low_len, sk_viol, di_viol, gap_viol, idle_viol, rises_seen;
    logic msk, mcs, mdi;
    always @(posedge clk) begin
        if (rst) begin
            seg <= 0; low_len <= 1000; sk_viol <= 0; di_viol <= 0; gap_viol <= 0;
            idle_viol <= 0; rises_seen <= 0; msk <= 0; mcs <= 0; mdi <= 0;
        end else begin
            msk <= sk; mcs <= cs; mdi <= di;
            if (!cs && sk) idle_viol <= idle_viol + 1;
            if (sk && msk && di != mdi) di_viol <= di_viol + 1;
            if (cs && !mcs) begin
                seg <= 1;
                if (low_len < GAPC) gap_viol <= gap_viol + 1;
                rises_seen <= rises_seen + 1;
            end else if (sk != msk) begin
                if (seg != HALF) sk_viol <= sk_viol + 1;
                seg <= 1;
            end else begin
                seg <= seg + 1;
            end
            low_len <= cs ? 0 : low_len + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d,
                           output bit got, output int cyc);
        @(negedge clk);
        start = 1; op_in = op; addr_in = a; wd_in = d;
        @(negedge clk);
        start = 0;
        got = 0;
        cyc = 1;
        for (int i = 0; i < 5000; i++) begin
            if (done) begin
                got = 1;
                break;
            end
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit   got;
        int   cyc, dones;
        logic [2:0]  vop;
        logic [5:0]  va;
        logic [15:0] vd, vexp;
        logic [4:0]  vclk;

        rst = 1; start = 0; op_in = 0; addr_in = 0; wd_in = 0; stuck = 0;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        chk({cs, sk, busy, done, tmo} == 5'b0, "R10", "control outputs after reset",
            {cs, sk, busy, done, tmo}, 0);
        chk(rd == 16'h0, "R10", "read word after reset", rd, 0);

        for (int i = 0; i < NVEC; i++) begin
            {vop, va, vd, vexp, vclk} = VEC[i];
            run_cmd(vop, va, vd, got, cyc);
            chk(got, "R9", "done seen", got, 1);
            chk(!tmo, "R6", "no timeout on ready memory", tmo, 0);
            if (vop == 3'd0) chk(rd == vexp, "R3", "read word", rd, vexp);
            if (vclk == 5'd25)      chk(last_clks == 25, "R2", "data frame clocks", last_clks, 25);
            else if (vclk == 5'd26) chk(last_clks == 26, "R3", "read frame clocks", last_clks, 26);
            else                    chk(last_clks == 9, "R1", "short frame clocks", last_clks, 9);
            @(negedge clk);
            chk(!done, "R9", "done is one cycle", done, 0);
        end

        // R6: completion waits for the memory's busy interval
        run_cmd(3'd1, 6'd9, 16'h1357, got, cyc);
        chk(got && cyc > BUSYC, "R6", "poll waits for ready", cyc, BUSYC);

        // R8: conflicting start in mid-read is ignored
        @(negedge clk);
        start = 1; op_in = 3'd0; addr_in = 6'd9; wd_in = 16'h0;
        @(negedge clk);
        start = 0;
        chk(busy, "R9", "busy after accepted start", busy, 1);
        repeat (6) @(negedge clk);
        start = 1; op_in = 3'd1; addr_in = 6'd9; wd_in = 16'h0000;
        @(negedge clk);
        start = 0;
        dones = 0;
        for (int i = 0; i < 600; i++) begin
            if (done) dones++;
            @(negedge clk);
        end
        chk(dones == 1, "R8", "single completion", dones, 1);
        chk(rd == 16'h1357, "R8", "read unaffected", rd, 16'h1357);
        chk(!busy && !cs, "R8", "no extra command", {busy, cs}, 0);
        run_cmd(3'd0, 6'd9, 16'h0, got, cyc);
        chk(rd == 16'h1357, "R8", "ignored write left word", rd, 16'h1357);

        // R7: memory never reports ready
        stuck = 1;
        run_cmd(3'd1, 6'd2, 16'hBEEF, got, cyc);
        chk(got && tmo, "R7", "timeout flag with done", tmo, 1);
        chk(!cs, "R7", "chip select dropped", cs, 0);
        chk(cyc >= PLIM, "R7", "poll window length", cyc, PLIM);
        stuck = 0;
        repeat (60) @(negedge clk);
        run_cmd(3'd0, 6'd2, 16'h0, got, cyc);
        chk(!tmo, "R7", "timeout clears on next command", tmo, 0);
        chk(rd == 16'hBEEF, "R3", "read after timeout", rd, 16'hBEEF);

        chk(sk_viol == 0, "R4", "clock half-period violations", sk_viol, 0);
        chk(di_viol == 0, "R4", "DI moved while clock high", di_viol, 0);
        chk(idle_viol == 0, "R4", "clock high with chip select low", idle_viol, 0);
        chk(gap_viol == 0 && rises_seen > 20, "R5", "short chip select gaps", gap_viol, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule